// File: doc/BRIEF.md
# Subscriber Line Frame Formatter

This block produces the transmit bit stream for a two-wire subscriber loop. At every frame boundary it samples a set of per-frame channel inputs and a small configuration: the line rate, framed or modem operation, and whether the D channel is carried in the B1 slot. It forms one frame word from these values and sends it bit by bit. Each bit is biphase coded, so every bit cell has a level change at its midpoint. The surrounding logic supplies a strobe at twice the baud rate. Each strobe advances the output by one half-cell.

In framed operation, the low rate sends 10 bits per frame and the high rate sends 20. Each framed frame starts with a sync bit whose value alternates from one frame to the next. The housekeeping bit and the D-channel bits follow the sync bit, and the B channels come after them. In modem operation no framing bits are sent, and every bit position carries data. A disable pin or a bit in a diagnostics control word forces the output to the neutral idle level. While the output is idle, the framing sequence keeps running in the background.

Top module: `sfl_line_tx`

## Requirements
- R1: While `rst` is high, and after reset until the first `half_en` strobe, `tx_active`, `tx_level` and `frame_mark` are 0.
- R2: Outputs change only on a clock edge where `half_en` is 1. A data 1 is sent as level 1 in the first half-cell and level 0 in the second. A data 0 is sent as 0 then 1.
- R3: In framed low-rate operation (`modem_mode`=0, `rate_hi`=0), a frame is 10 bits in this order: sync, `d_data[0]`, then `b1_data` bits 7 down to 0.
- R4: In framed high-rate operation (`rate_hi`=1), a frame is 20 bits in this order: sync, `hk_bit`, `d_data[1]`, `d_data[0]`, `b1_data[7:0]`, then `b2_data[7:0]`. Each channel is sent MSB first.
- R5: With `d_in_b1`=1 in framed operation, the B1 slot carries `d_data[7:0]` MSB first, and the D-bit positions are sent as 1.
- R6: In modem operation, the low rate sends `b1_data[7:0]` then `d_data[1:0]` (10 bits). The high rate sends `b1_data`, then `b2_data`, then `d_data[3:0]` (20 bits). Sync and housekeeping bits are not sent, and `d_in_b1` has no effect.
- R7: The sync bit of the first frame after reset is 1. The sync value inverts at every frame boundary.
- R8: All channel and configuration inputs are sampled only at a frame boundary. Changes made mid-frame do not alter the frame being sent.
- R9: While `line_dis` is 1, `tx_active` and `tx_level` are 0 in the same cycle. Frame timing continues, so output resumes at the current position of the sequence.
- R10: Bit 6 of `diag_ctrl` disables the output in the same way as `line_dis`. The other bits of `diag_ctrl` have no effect.
- R11: `frame_mark` is 1 exactly during the first half-cell of each frame, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Strobe at twice the baud rate; advances one half-cell |
| rate_hi | input | 1 | 1 selects 20-bit frames, 0 selects 10-bit frames |
| modem_mode | input | 1 | 1 sends an unframed data stream |
| d_in_b1 | input | 1 | Carries the D channel in the B1 slot |
| hk_bit | input | 1 | Housekeeping bit |
| b1_data | input | 8 | B1 channel octet |
| b2_data | input | 8 | B2 channel octet |
| d_data | input | 8 | D-channel bits for this frame |
| line_dis | input | 1 | Forces idle output; 0 means enabled |
| diag_ctrl | input | 8 | Diagnostics control word; bit 6 disables output |
| tx_level | output | 1 | Biphase line level |
| tx_active | output | 1 | 1 when driving; 0 means idle bias |
| frame_mark | output | 1 | High during the first half-cell of a frame |

## Verification
The bench runs each combination of the two rates and the two modes with fixed asymmetric octets, which exposes bit-order and slot-position errors. The D-in-B1 option is run at both rates with an octet that differs from B1, so a missing slot substitution is visible. A phase that changes every input at every strobe separates sampling at frame boundaries from sampling during the frame. Uneven strobe spacing checks that the output advances only on a strobe. Disable pulses from each source, and diagnostic words with all bits except bit 6 set, check the idle forcing and check that other diagnostic bits are ignored.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    typedef struct packed {
        logic rate_hi;
        logic modem;
        logic d_in_b1;
    } sfl_cfg_t;

    typedef enum logic {
        CELL_FIRST  = 1'b0,
        CELL_SECOND = 1'b1
    } cell_half_e;

    // Line level of one half-cell: data level first, inverted level second.
    function automatic logic cell_level(input logic data_bit, input cell_half_e half);
        return data_bit ^ (half == CELL_SECOND);
    endfunction

endpackage

// File: rtl/sfl_frame_build.sv
module sfl_frame_build
    import sfl_pkg::*;
#(
    parameter int B_W = 8,
    localparam int FW = 2 * B_W + 4,
    localparam int LW = $clog2(FW + 1)
) (
    input  sfl_cfg_t          cfg,
    input  logic              sync_bit,
    input  logic              hk_bit,
    input  logic [B_W-1:0]    b1,
    input  logic [B_W-1:0]    b2,
    input  logic [B_W-1:0]    dch,
    output logic [FW-1:0]     word,
    output logic [LW-1:0]     len
);
    localparam int HALF = FW / 2;

    logic [B_W-1:0] b1_slot;
    logic [1:0]     dpos;

    always_comb begin
        b1_slot = cfg.d_in_b1 ? dch : b1;
        dpos    = cfg.d_in_b1 ? 2'b11 : dch[1:0];
        if (cfg.modem) begin
            if (cfg.rate_hi) word = {b1, b2, dch[3:0]};
            else             word = {b1, dch[1:0], {HALF{1'b0}}};
        end else begin
            if (cfg.rate_hi) word = {sync_bit, hk_bit, dpos[1], dpos[0], b1_slot, b2};
            else             word = {sync_bit, dpos[0], b1_slot, {HALF{1'b0}}};
        end
        len = cfg.rate_hi ? LW'(FW) : LW'(HALF);
    end

endmodule

// File: rtl/sfl_cell_seq.sv
module sfl_cell_seq
    import sfl_pkg::*;
#(
    parameter int FW = 20,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          half_en,
    input  logic [FW-1:0] word_in,
    input  logic [LW-1:0] len_in,
    output logic          sync_next,
    output logic          lvl,
    output logic          started,
    output logic          mark
);
    logic [FW-1:0] frame_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;
    cell_half_e    ph_q;
    logic          lvl_q;
    logic          started_q;
    logic          mark_q;
    logic          sync_q;
    logic          last_cell;
    logic          load;

    assign last_cell = (ph_q == CELL_SECOND) && ((idx_q + LW'(1)) == len_q);
    assign load      = half_en && (!started_q || last_cell);
    assign sync_next = ~sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= '0;
            len_q     <= '0;
            idx_q     <= '0;
            ph_q      <= CELL_FIRST;
            lvl_q     <= 1'b0;
            started_q <= 1'b0;
            mark_q    <= 1'b0;
            sync_q    <= 1'b0;
        end else if (half_en) begin
            if (load) begin
                frame_q   <= word_in;
                len_q     <= len_in;
                idx_q     <= '0;
                ph_q      <= CELL_FIRST;
                lvl_q     <= cell_level(word_in[FW-1], CELL_FIRST);
                started_q <= 1'b1;
                mark_q    <= 1'b1;
                sync_q    <= ~sync_q;
            end else if (ph_q == CELL_FIRST) begin
                ph_q   <= CELL_SECOND;
                lvl_q  <= cell_level(frame_q[FW-1], CELL_SECOND);
                mark_q <= 1'b0;
            end else begin
                frame_q <= frame_q << 1;
                idx_q   <= idx_q + LW'(1);
                ph_q    <= CELL_FIRST;
                lvl_q   <= cell_level(frame_q[FW-2], CELL_FIRST);
                mark_q  <= 1'b0;
            end
        end
    end

    assign lvl     = lvl_q;
    assign started = started_q;
    assign mark    = mark_q;

    // R2: no movement between strobes
    a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !half_en |=> ($stable(lvl_q) && $stable(mark_q)));

    // R2: a strobe leaving the first half-cell always yields a level change
    a_r2_mid_transition: assert property (@(posedge clk) disable iff (rst)
        (half_en && started_q && ph_q == CELL_FIRST) |=> (lvl_q != $past(lvl_q)));

    // R8: the latched frame only changes on a load
    a_r8_frame_held: assert property (@(posedge clk) disable iff (rst)
        (started_q && !load) |=> ($stable(len_q) && (idx_q <= len_q)));

    // R11: the frame marker never covers a second half-cell
    a_r11_mark_first_half: assert property (@(posedge clk) disable iff (rst)
        mark_q |-> (ph_q == CELL_FIRST));

    // R7: sync value flips on each frame boundary
    a_r7_sync_flip: assert property (@(posedge clk) disable iff (rst)
        load |=> (sync_q != $past(sync_q)));

endmodule

// File: rtl/sfl_line_tx.sv
module sfl_line_tx
    import sfl_pkg::*;
#(
    parameter int B_W     = 8,
    parameter int DIAG_W  = 8,
    parameter int DIS_BIT = 6,
    localparam int FW = 2 * B_W + 4,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_en,
    input  logic              rate_hi,
    input  logic              modem_mode,
    input  logic              d_in_b1,
    input  logic              hk_bit,
    input  logic [B_W-1:0]    b1_data,
    input  logic [B_W-1:0]    b2_data,
    input  logic [B_W-1:0]    d_data,
    input  logic              line_dis,
    input  logic [DIAG_W-1:0] diag_ctrl,
    output logic              tx_level,
    output logic              tx_active,
    output logic              frame_mark
);
    sfl_cfg_t      cfg;
    logic [FW-1:0] word;
    logic [LW-1:0] len;
    logic          sync_next;
    logic          cell_lvl;
    logic          started;
    logic          off;
    logic          unused_diag;

    assign cfg = '{rate_hi: rate_hi, modem: modem_mode, d_in_b1: d_in_b1};

    sfl_frame_build #(.B_W(B_W)) u_build (
        .cfg      (cfg),
        .sync_bit (sync_next),
        .hk_bit   (hk_bit),
        .b1       (b1_data),
        .b2       (b2_data),
        .dch      (d_data),
        .word     (word),
        .len      (len)
    );

    sfl_cell_seq #(.FW(FW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .half_en   (half_en),
        .word_in   (word),
        .len_in    (len),
        .sync_next (sync_next),
        .lvl       (cell_lvl),
        .started   (started),
        .mark      (frame_mark)
    );

    assign unused_diag = ^diag_ctrl;
    assign off         = line_dis | diag_ctrl[DIS_BIT];
    assign tx_active   = started & ~off;
    assign tx_level    = tx_active & cell_lvl;

endmodule

// File: tb/tb_sfl_line_tx.sv
`timescale 1ns/1ps
module tb_sfl_line_tx;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic half_en = 1'b0;
    logic rate_hi = 1'b0, modem_mode = 1'b0, d_in_b1 = 1'b0, hk_bit = 1'b0;
    logic [7:0] b1_data = '0, b2_data = '0, d_data = '0, diag_ctrl = '0;
    logic line_dis = 1'b0;
    logic tx_level, tx_active, frame_mark;

    always #2.5 clk = ~clk;

    sfl_line_tx dut (
        .clk(clk), .rst(rst), .half_en(half_en), .rate_hi(rate_hi),
        .modem_mode(modem_mode), .d_in_b1(d_in_b1), .hk_bit(hk_bit),
        .b1_data(b1_data), .b2_data(b2_data), .d_data(d_data),
        .line_dis(line_dis), .diag_ctrl(diag_ctrl),
        .tx_level(tx_level), .tx_active(tx_active), .frame_mark(frame_mark)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference: queue of half-cell levels and frame markers
    bit lv_q[$];
    bit mk_q[$];
    bit msync = 0;
    bit exp_lvl = 0, exp_mark = 0, exp_started = 0;

    task automatic build_frame();
        bit bs[$];
        logic [7:0] slot;
        msync = ~msync;
        if (modem_mode) begin
            for (int i = 7; i >= 0; i--) bs.push_back(b1_data[i]);
            if (rate_hi) begin
                for (int i = 7; i >= 0; i--) bs.push_back(b2_data[i]);
                for (int i = 3; i >= 0; i--) bs.push_back(d_data[i]);
            end else begin
                bs.push_back(d_data[1]);
                bs.push_back(d_data[0]);
            end
        end else begin
            bs.push_back(msync);
            if (rate_hi) begin
                bs.push_back(hk_bit);
                bs.push_back(d_in_b1 ? 1'b1 : d_data[1]);
            end
            bs.push_back(d_in_b1 ? 1'b1 : d_data[0]);
            slot = d_in_b1 ? d_data : b1_data;
            for (int i = 7; i >= 0; i--) bs.push_back(slot[i]);
            if (rate_hi) for (int i = 7; i >= 0; i--) bs.push_back(b2_data[i]);
        end
        foreach (bs[k]) begin
            lv_q.push_back(bs[k]);  mk_q.push_back(k == 0);
            lv_q.push_back(!bs[k]); mk_q.push_back(1'b0);
        end
    endtask

    task automatic model_advance();
        if (lv_q.size() == 0) build_frame();
        exp_lvl     = lv_q.pop_front();
        exp_mark    = mk_q.pop_front();
        exp_started = 1;
    endtask

    task automatic model_reset();
        lv_q.delete(); mk_q.delete();
        msync = 0; exp_lvl = 0; exp_mark = 0; exp_started = 0;
    endtask

    task automatic check_bit(input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        logic act;
        act = exp_started && !(line_dis || diag_ctrl[6]);
        check_bit("tx_active", tx_active, act);
        check_bit("tx_level", tx_level, act & exp_lvl);
        check_bit("frame_mark", frame_mark, exp_mark);
    endtask

    // drive for one clock, then compare after the edge
    task automatic step(input bit he);
        half_en = he;
        if (rst) model_reset();
        else if (he) model_advance();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input int period);
        for (int c = 0; c < n; c++) step((c % period) == 0);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state, strobes ignored
        cur_req = "R1";
        rst = 1;
        for (int i = 0; i < 4; i++) step(1);
        rst = 0;
        for (int i = 0; i < 3; i++) step(0);

        // R3: framed low rate
        cur_req = "R3";
        b1_data = 8'hA5; b2_data = 8'h0F; d_data = 8'h01; hk_bit = 1;
        run(120, 2);
        d_data = 8'h00; b1_data = 8'h3B;
        run(80, 2);

        // R4: framed high rate
        cur_req = "R4";
        rate_hi = 1; b1_data = 8'h3C; b2_data = 8'hC1; d_data = 8'h02; hk_bit = 1;
        run(160, 2);
        hk_bit = 0; d_data = 8'h01;
        run(160, 2);

        // R5: D channel carried in the B1 slot, both rates
        cur_req = "R5";
        d_in_b1 = 1; d_data = 8'h96; b1_data = 8'h00;
        run(160, 2);
        rate_hi = 0;
        run(120, 2);
        d_in_b1 = 0;

        // R6: modem stream, both rates (d_in_b1 set must not matter)
        cur_req = "R6";
        modem_mode = 1; d_in_b1 = 1; b1_data = 8'hE2; b2_data = 8'h47; d_data = 8'h0B;
        run(120, 2);
        rate_hi = 1;
        run(200, 2);
        modem_mode = 0; d_in_b1 = 0;

        // R7: many framed frames, sync alternation
        cur_req = "R7";
        rate_hi = 0; b1_data = 8'hFF; d_data = 8'h01;
        run(200, 2);

        // R2: uneven strobe spacing
        cur_req = "R2";
        rate_hi = 1; b1_data = 8'h5A; b2_data = 8'h81;
        run(180, 3);
        for (int i = 0; i < 60; i++) step(i % 5 == 0 || i % 5 == 1);

        // R8: inputs churn at every strobe
        cur_req = "R8";
        for (int i = 0; i < 400; i++) begin
            if (i % 2 == 0) begin
                b1_data = 8'($urandom); b2_data = 8'($urandom);
                d_data = 8'($urandom); hk_bit = 1'($urandom);
                rate_hi = 1'($urandom); modem_mode = 1'($urandom); d_in_b1 = 1'($urandom);
            end
            step(i % 2 == 0);
        end
        modem_mode = 0; d_in_b1 = 0; rate_hi = 1;

        // R9: disable pin mid-frame
        cur_req = "R9";
        run(17, 2);
        line_dis = 1;
        run(30, 2);
        line_dis = 0;
        run(40, 2);

        // R10: diagnostics bit 6, then all other bits
        cur_req = "R10";
        diag_ctrl = 8'h40;
        run(30, 2);
        diag_ctrl = 8'hBF;
        run(60, 2);
        diag_ctrl = 8'h00;

        // R11: frame markers over low and high frames
        cur_req = "R11";
        rate_hi = 0;
        run(100, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule